// File: doc/BRIEF.md
# Power-Management Timer with Overflow Event Registers

This block keeps a free-running up-counter for power-management timekeeping and a pair of 16-bit event registers, one for status and one for enable, that report when the counter wraps. Logic outside the block produces a one-cycle tick strobe at the fixed reference rate, nominally 3.579545 MHz. Each strobe advances the counter by one. When the counter rolls over from all ones to zero, a sticky overflow flag is set in the status register. If the matching enable bit is set at that moment, the block raises an interrupt request and clears the whole enable register, so the interrupt fires only once. Software must re-arm it by writing the enable bit again.

Software reaches the block through a small word-addressed register port. Commands use a valid/ready handshake and responses use a second valid/ready channel. Every accepted command, read or write, returns exactly one response beat. Only one response can be pending at a time, so a stalled response channel back-pressures the command channel: `cmd_ready_o` is high only when no response is held or the held one is being taken in the same cycle. Word 0 is the event block. A read of it returns status in bits 15:0 and enable in bits 31:16, so software can use either half or the whole word. Word 1 holds the timer value.

Top module: `pm_timer_evt`

## Requirements
- R1: Each cycle with `tick_i` high adds one to the counter. With `tick_i` low the counter holds its value.
- R2: A tick taken while the counter is all ones leaves the counter at zero and sets status bit 0, the overflow flag, on the same edge.
- R3: If enable bit 0 is set when R2 happens, `irq_o` is high from the next cycle. Otherwise `irq_o` does not rise.
- R4: Raising the interrupt clears all 16 enable bits to zero. A later overflow raises no interrupt until software writes enable bit 0 to 1 again.
- R5: Status bits are write-one-to-clear. Writing 1 to bit 0 through byte lane 0 clears it. Writing 0, or writing with lane 0 unselected, leaves it unchanged. An overflow on the same edge as a clear leaves the flag set.
- R6: `irq_o` falls in the cycle after a write that clears the overflow flag.
- R7: The address map is as follows. Word 0 reads {enable, status}. Byte lanes 0 and 1 of a write to word 0 act on status, and lanes 2 and 3 replace the enable bytes. Word 1 reads the counter zero-extended to 32 bits, and writes to it are ignored. Other words read zero.
- R8: Each accepted command produces one response in the next cycle. While `rsp_valid_o` is high and `rsp_ready_i` is low, `cmd_ready_o` is low, and the response stays valid with stable data.
- R9: Synchronous reset clears the counter, status, enable and `irq_o`.
- R10: All 16 enable bits store what is written. Status bits other than bit 0 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | One-cycle timer advance strobe |
| cmd_valid_i | input | 1 | Command present |
| cmd_ready_o | output | 1 | Command accepted this cycle when high with valid |
| cmd_write_i | input | 1 | 1 = write, 0 = read |
| cmd_addr_i | input | ADDR_W | Word address |
| cmd_wdata_i | input | 32 | Write data |
| cmd_strb_i | input | 4 | Byte lane selects for writes |
| rsp_valid_o | output | 1 | Response present |
| rsp_ready_i | input | 1 | Response taken when high with valid |
| rsp_rdata_o | output | 32 | Read data captured when the command was accepted |
| irq_o | output | 1 | Overflow interrupt request, level |

## Verification
The bench builds the block with a 5-bit counter and keeps the 16-bit event registers at their full width. With a 5-bit counter a wrap takes only 32 ticks. The bench therefore steps through more than two full counter periods and reads the counter after every tick. It also reaches the one-shot arm, fire and re-arm sequence several times, and can put a status clear on the same edge as a wrap. Response back-pressure, writes to the timer word and unmapped words are driven against a model counter kept in the bench.

// File: rtl/pmt_pkg.sv
package pmt_pkg;

  // word offsets inside the register window
  localparam int unsigned EVT_WORD = 0;
  localparam int unsigned TMR_WORD = 1;

  typedef enum logic [1:0] {
    SEL_EVT  = 2'd0,
    SEL_TMR  = 2'd1,
    SEL_NONE = 2'd2
  } pmt_sel_e;

endpackage

// File: rtl/pmt_counter.sv
module pmt_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = tick_i && (cnt_q == CNT_MAX);

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    tick_i |=> cnt_o == $past(cnt_o) + 1'b1); // R1
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tick_i |=> $stable(cnt_o)); // R1
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
    wrap_o |=> cnt_o == '0); // R2

endmodule

// File: rtl/pmt_evt_regs.sv
module pmt_evt_regs #(
  parameter int STS_W   = 16,
  parameter int OVF_BIT = 0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wrap_i,
  input  logic [STS_W-1:0]   clr_i,
  input  logic [STS_W/8-1:0] en_be_i,
  input  logic [STS_W-1:0]   en_wdata_i,
  output logic [STS_W-1:0]   sts_o,
  output logic [STS_W-1:0]   en_o,
  output logic               irq_o
);

  localparam int NLANE = STS_W / 8;
  localparam logic [STS_W-1:0] IMPL = {{(STS_W-1){1'b0}}, 1'b1} << OVF_BIT;

  logic [STS_W-1:0] sts_q, en_q, en_wr;
  logic             armed_q;
  logic             raise;

  // per-lane replacement of the enable bytes
  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    assign en_wr[l*8 +: 8] = en_be_i[l] ? en_wdata_i[l*8 +: 8] : en_q[l*8 +: 8];
  end

  assign raise = wrap_i && en_q[OVF_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      sts_q   <= '0;
      en_q    <= '0;
      armed_q <= 1'b0;
    end else begin
      // set beats clear: the overflow is OR-ed in after the clear mask
      sts_q <= ((sts_q & ~clr_i) | (wrap_i ? IMPL : '0)) & IMPL;
      en_q  <= raise ? '0 : en_wr;
      if (raise)                            armed_q <= 1'b1;
      else if (clr_i[OVF_BIT] && !wrap_i)   armed_q <= 1'b0;
    end
  end

  assign sts_o = sts_q;
  assign en_o  = en_q;
  assign irq_o = sts_q[OVF_BIT] && armed_q;

  AST_WRAP_STS: assert property (@(posedge clk) disable iff (rst)
    wrap_i |=> sts_o[OVF_BIT]); // R2
  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (rst)
    (wrap_i && en_o[OVF_BIT]) |=> irq_o); // R3
  AST_NO_IRQ_UNARMED: assert property (@(posedge clk) disable iff (rst)
    (!irq_o && !(wrap_i && en_o[OVF_BIT])) |=> !irq_o); // R3
  AST_ONESHOT: assert property (@(posedge clk) disable iff (rst)
    (wrap_i && en_o[OVF_BIT]) |=> en_o == '0); // R4
  AST_IRQ_DROP: assert property (@(posedge clk) disable iff (rst)
    (clr_i[OVF_BIT] && !wrap_i) |=> !irq_o); // R6

endmodule

// File: rtl/pmt_reg_port.sv
module pmt_reg_port
  import pmt_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int CNT_W  = 24,
  parameter int STS_W  = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cmd_valid_i,
  output logic                 cmd_ready_o,
  input  logic                 cmd_write_i,
  input  logic [ADDR_W-1:0]    cmd_addr_i,
  input  logic [2*STS_W-1:0]   cmd_wdata_i,
  input  logic [STS_W/4-1:0]   cmd_strb_i,
  output logic                 rsp_valid_o,
  input  logic                 rsp_ready_i,
  output logic [2*STS_W-1:0]   rsp_rdata_o,
  input  logic [CNT_W-1:0]     cnt_i,
  input  logic [STS_W-1:0]     sts_i,
  input  logic [STS_W-1:0]     en_i,
  output logic [STS_W-1:0]     clr_o,
  output logic [STS_W/8-1:0]   en_be_o,
  output logic [STS_W-1:0]     en_wdata_o
);

  localparam int DATA_W = 2 * STS_W;
  localparam int NLANE  = STS_W / 8;

  pmt_sel_e           sel;
  logic               acc, wr_evt;
  logic [STS_W-1:0]   sts_lane_mask;
  logic [DATA_W-1:0]  rd_mux;
  logic               rsp_valid_q;
  logic [DATA_W-1:0]  rsp_rdata_q;

  always_comb begin
    if (cmd_addr_i == ADDR_W'(EVT_WORD))      sel = SEL_EVT;
    else if (cmd_addr_i == ADDR_W'(TMR_WORD)) sel = SEL_TMR;
    else                                      sel = SEL_NONE;
  end

  assign cmd_ready_o = !rsp_valid_q || rsp_ready_i;
  assign acc         = cmd_valid_i && cmd_ready_o;
  assign wr_evt      = acc && cmd_write_i && (sel == SEL_EVT);

  for (genvar l = 0; l < NLANE; l++) begin : g_mask
    assign sts_lane_mask[l*8 +: 8] = {8{cmd_strb_i[l]}};
  end

  assign clr_o      = wr_evt ? (cmd_wdata_i[STS_W-1:0] & sts_lane_mask) : '0;
  assign en_be_o    = wr_evt ? cmd_strb_i[2*NLANE-1:NLANE] : '0;
  assign en_wdata_o = cmd_wdata_i[DATA_W-1:STS_W];

  always_comb begin
    case (sel)
      SEL_EVT: rd_mux = {en_i, sts_i};
      SEL_TMR: rd_mux = {{(DATA_W-CNT_W){1'b0}}, cnt_i};
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else if (acc) begin
      rsp_valid_q <= 1'b1;
      rsp_rdata_q <= cmd_write_i ? '0 : rd_mux;
    end else if (rsp_ready_i) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = rsp_rdata_q;

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid_o && !rsp_ready_i) |=> (rsp_valid_o && $stable(rsp_rdata_o))); // R8
  AST_RSP_AFTER_ACC: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid_i && cmd_ready_o) |=> rsp_valid_o); // R8

endmodule

// File: rtl/pm_timer_evt.sv
module pm_timer_evt #(
  parameter int CNT_W   = 24,
  parameter int STS_W   = 16,
  parameter int OVF_BIT = 0,
  parameter int ADDR_W  = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick_i,
  input  logic                cmd_valid_i,
  output logic                cmd_ready_o,
  input  logic                cmd_write_i,
  input  logic [ADDR_W-1:0]   cmd_addr_i,
  input  logic [2*STS_W-1:0]  cmd_wdata_i,
  input  logic [STS_W/4-1:0]  cmd_strb_i,
  output logic                rsp_valid_o,
  input  logic                rsp_ready_i,
  output logic [2*STS_W-1:0]  rsp_rdata_o,
  output logic                irq_o
);

  localparam int NLANE = STS_W / 8;

  logic [CNT_W-1:0] cnt;
  logic             wrap;
  logic [STS_W-1:0] sts, en, clr, en_wdata;
  logic [NLANE-1:0] en_be;

  pmt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .tick_i (tick_i),
    .cnt_o  (cnt),
    .wrap_o (wrap)
  );

  pmt_evt_regs #(.STS_W(STS_W), .OVF_BIT(OVF_BIT)) u_evt (
    .clk        (clk),
    .rst        (rst),
    .wrap_i     (wrap),
    .clr_i      (clr),
    .en_be_i    (en_be),
    .en_wdata_i (en_wdata),
    .sts_o      (sts),
    .en_o       (en),
    .irq_o      (irq_o)
  );

  pmt_reg_port #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .STS_W(STS_W)) u_port (
    .clk         (clk),
    .rst         (rst),
    .cmd_valid_i (cmd_valid_i),
    .cmd_ready_o (cmd_ready_o),
    .cmd_write_i (cmd_write_i),
    .cmd_addr_i  (cmd_addr_i),
    .cmd_wdata_i (cmd_wdata_i),
    .cmd_strb_i  (cmd_strb_i),
    .rsp_valid_o (rsp_valid_o),
    .rsp_ready_i (rsp_ready_i),
    .rsp_rdata_o (rsp_rdata_o),
    .cnt_i       (cnt),
    .sts_i       (sts),
    .en_i        (en),
    .clr_o       (clr),
    .en_be_o     (en_be),
    .en_wdata_o  (en_wdata)
  );

  AST_RST_QUIET: assert property (@(posedge clk)
    rst |=> (!irq_o && !rsp_valid_o)); // R9

endmodule

// File: tb/sim_pm_timer_evt.sv
module sim_pm_timer_evt;

  localparam int CW   = 5;
  localparam int MAXC = (1 << CW) - 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic        cmd_write = 1'b0;
  logic [1:0]  cmd_addr = '0;
  logic [31:0] cmd_wdata = '0;
  logic [3:0]  cmd_strb = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_rdata;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  int m_cnt = 0;
  logic [15:0] m_sts = '0;
  logic [15:0] m_en = '0;
  logic        m_irq = 1'b0;
  logic [31:0] rd;

  always #2 clk = ~clk;

  pm_timer_evt #(.CNT_W(CW)) u0 (
    .clk(clk), .rst(rst), .tick_i(tick),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready), .cmd_write_i(cmd_write),
    .cmd_addr_i(cmd_addr), .cmd_wdata_i(cmd_wdata), .cmd_strb_i(cmd_strb),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_rdata_o(rsp_rdata),
    .irq_o(irq)
  );

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_tick();
    if (m_cnt == MAXC) begin
      m_cnt = 0;
      m_sts[0] = 1'b1;
      if (m_en[0]) begin
        m_irq = 1'b1;
        m_en = '0;
      end
    end else begin
      m_cnt++;
    end
  endtask

  task automatic do_tick(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      model_tick();
    end
  endtask

  task automatic bus(input logic wr, input logic [1:0] a, input logic [31:0] wd,
                     input logic [3:0] sb, input logic tk, output logic [31:0] r);
    cmd_valid = 1'b1; cmd_write = wr; cmd_addr = a; cmd_wdata = wd; cmd_strb = sb;
    tick = tk;
    @(negedge clk);
    cmd_valid = 1'b0; tick = 1'b0;
    check(rsp_valid === 1'b1, "R8 rsp after accept", {31'b0, rsp_valid}, 32'h1);
    r = rsp_rdata;
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic rd_tmr(input string req);
    bus(1'b0, 2'd1, '0, '0, 1'b0, rd);
    check(rd === 32'(m_cnt), req, rd, 32'(m_cnt));
  endtask

  task automatic rd_evt(input string req);
    bus(1'b0, 2'd0, '0, '0, 1'b0, rd);
    check(rd === {m_en, m_sts}, req, rd, {m_en, m_sts});
  endtask

  task automatic chk_irq(input string req);
    check(irq === m_irq, req, {31'b0, irq}, {31'b0, m_irq});
  endtask

  task automatic clr_sts();
    bus(1'b1, 2'd0, 32'h0000_0001, 4'b0001, 1'b0, rd);
    m_sts[0] = 1'b0;
    m_irq = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R9: reset state
    chk_irq("R9 irq after reset");
    rd_evt("R9 event regs after reset");
    rd_tmr("R9 timer after reset");

    // R1 / R2 / R3: counter sweep over more than two periods, enable off
    for (int i = 0; i < 2 * (MAXC + 1) + 6; i++) begin
      do_tick(1);
      rd_tmr("R1 counter after tick");
      if (m_cnt == 0) begin
        rd_evt("R2 overflow flag after wrap");
        chk_irq("R3 no irq while disabled");
      end
    end
    // R1: idle cycles hold the count
    repeat (5) @(negedge clk);
    rd_tmr("R1 hold without tick");

    // R10: unimplemented status bits stay zero
    rd_evt("R10 only bit 0 in status");

    // R5: write-one-to-clear rules
    bus(1'b1, 2'd0, 32'h0000_0000, 4'b0011, 1'b0, rd);
    rd_evt("R5 writing zero keeps flag");
    bus(1'b1, 2'd0, 32'h0000_FFFF, 4'b0010, 1'b0, rd);
    rd_evt("R5 lane 0 unselected keeps flag");
    bus(1'b1, 2'd0, 32'h0000_FFFF, 4'b0011, 1'b0, rd);
    m_sts = '0;
    rd_evt("R5 writing one clears flag");

    // R10 / R7: enable stores all bits, byte lanes apply
    bus(1'b1, 2'd0, 32'hA5C3_0000, 4'b1100, 1'b0, rd);
    m_en = 16'hA5C3;
    rd_evt("R10 enable readback");
    bus(1'b1, 2'd0, 32'h7E00_0000, 4'b1000, 1'b0, rd);
    m_en[15:8] = 8'h7E;
    rd_evt("R7 upper enable lane only");

    // R3 / R4: armed overflow
    while (m_cnt != MAXC) do_tick(1);
    chk_irq("R3 irq low before wrap");
    do_tick(1);
    chk_irq("R3 irq raised on wrap");
    rd_evt("R4 enable cleared on raise");
    repeat (3) @(negedge clk);
    chk_irq("R3 irq holds as level");

    // R6: clearing status drops irq
    clr_sts();
    chk_irq("R6 irq drops after clear");

    // R4: not re-armed, no further irq
    do_tick(MAXC + 1);
    chk_irq("R4 no irq without re-arm");
    rd_evt("R4 flag set but enable zero");
    clr_sts();

    // R4: re-arm fires again
    bus(1'b1, 2'd0, 32'h0001_0000, 4'b0100, 1'b0, rd);
    m_en = 16'h0001;
    do_tick(MAXC + 1);
    chk_irq("R4 irq after re-arm");
    clr_sts();
    chk_irq("R6 irq drops after second clear");

    // R5: overflow on same edge as clear keeps the flag
    while (m_cnt != MAXC) do_tick(1);
    bus(1'b1, 2'd0, 32'h0000_0001, 4'b0001, 1'b1, rd);
    m_sts[0] = 1'b0;
    model_tick();
    rd_evt("R5 overflow wins over clear");
    rd_tmr("R2 counter zero after wrap");
    clr_sts();

    // R7: timer writes ignored, unmapped word reads zero
    do_tick(7);
    bus(1'b1, 2'd1, 32'hFFFF_FFFF, 4'b1111, 1'b0, rd);
    rd_tmr("R7 timer write ignored");
    bus(1'b1, 2'd3, 32'hFFFF_FFFF, 4'b1111, 1'b0, rd);
    rd_evt("R7 unmapped write no effect");
    bus(1'b0, 2'd2, '0, '0, 1'b0, rd);
    check(rd === 32'h0, "R7 unmapped read zero", rd, 32'h0);

    // R8: back-pressure on the response channel
    cmd_valid = 1'b1; cmd_write = 1'b0; cmd_addr = 2'd1;
    @(negedge clk);
    begin
      logic [31:0] held;
      held = rsp_rdata;
      check(held === 32'(m_cnt), "R8 held read data", held, 32'(m_cnt));
      cmd_addr = 2'd0;
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        check(cmd_ready === 1'b0, "R8 cmd stalled", {31'b0, cmd_ready}, 32'h0);
        check(rsp_valid === 1'b1 && rsp_rdata === held, "R8 rsp stable",
              rsp_rdata, held);
      end
    end
    cmd_valid = 1'b0; rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    @(negedge clk);
    check(rsp_valid === 1'b0, "R8 single response", {31'b0, rsp_valid}, 32'h0);

    // R9: reset mid-run
    bus(1'b1, 2'd0, 32'hFFFF_0000, 4'b1100, 1'b0, rd);
    m_en = 16'hFFFF;
    while (m_cnt != MAXC) do_tick(1);
    do_tick(1);
    chk_irq("R9 irq before reset");
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    m_cnt = 0; m_sts = '0; m_en = '0; m_irq = 1'b0;
    chk_irq("R9 irq cleared by reset");
    rd_evt("R9 event regs cleared");
    rd_tmr("R9 counter cleared");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule